// File: doc/BRIEF.md
# Multi-CPU Interrupt Routing Controller

This block gathers 32 level-sensitive device interrupt lines, translates each through a fixed source-to-priority table into one of the processor levels 1 to 15, and delivers the combined result to a single software-selected CPU. Several sources that share a level are ORed onto that level. A source mapped to level 0 is dropped completely. A per-source disable mask and a global master-disable bit decide which pending sources reach the level outputs.

Sources at level 15 are treated as broadcast: each CPU sees them whether or not it is the selected target. For every CPU the block drives two 15-bit vectors. The first holds the active priority levels. The second is a routed-pending word for the per-CPU logic further downstream. Software works through a small word-addressed register window holding pending status, the disable mask, clear-mask and set-mask strobes, and the target selector.

Top module: `irq_router`

## Requirements
- R1: After reset the pending word is 0, the internal disable mask holds 0x0FA2007F (so reading offset 0x04 returns 0), the target selector is 0, and all level and routed outputs are 0. With the reset mask, source bit 7 is already enabled and bit 0 is disabled.
- R2: On every clock, pending bit j copies input j when source j has a non-zero level. Bits 23–26 and 31 never become pending. Reading offset 0x00 returns the pending word with bit 31 forced to 0.
- R3: Source bits 0..31 map to levels 2,3,5,7,9,11,13,2,3,5,7,9,11,13,12,12,6,13,4,10,8,9,11,0,0,0,0,15,15,15,15,0. Level L is carried on bit L-1 of each 15-bit output vector, and sources that share a level are ORed.
- R4: Writing offset 0x08 clears the mask bits set in (data AND 0xF05DFF80). Writing offset 0x0C sets those same bits. No other mask bit ever changes. Reading 0x04 returns the mask AND 0xF05DFF80.
- R5: While mask bit 31 (master disable) is set, every CPU's level vector is 0, including level 15.
- R6: Writing offset 0x10 loads the low 4 bits of the data into the target selector, and reading 0x10 returns it. A target value with no matching CPU sends device levels to no CPU.
- R7: Only the target CPU receives levels from pending sources that are not disabled. Disabled sources contribute nothing to the level vectors, except as R8 allows.
- R8: A pending source in bits 27–30 sets bit 14 (level 15) of every CPU's routed word. When master disable is clear, it also sets bit 14 of every CPU's level vector, whatever its own mask bit is.
- R9: The target CPU's routed word holds the levels of all pending sources, ignoring the mask and master disable. Every other CPU's routed word is 0 apart from the R8 broadcast bit.
- R10: Reads of any offset other than 0x00, 0x04 and 0x10 return 0. Writes to any offset other than 0x08, 0x0C and 0x10 change nothing.
- R11: A change on an input line shows on the outputs after the second rising clock edge. A register write shows after the rising edge that follows the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_lvl | input | 32 | Device interrupt levels, bit j is source j |
| bus_wr | input | 1 | Write strobe for one clock |
| bus_addr | input | 5 | Byte offset into the register window (low two bits ignored) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| lvl_out | output | NCPU*15 | Per-CPU active levels; CPU c on bits [c*15 +: 15], bit L-1 is level L |
| routed_out | output | NCPU*15 | Per-CPU routed-pending word, same layout |

## Verification
The bench builds the block with four CPUs and a 4-bit target selector. This lets it check every lane as target and as non-target in the same run, and also use selector values 4 to 15, which match no CPU, to cover the out-of-range target case. Because the reset mask leaves some sources permanently disabled once all writable bits are cleared, the vectors reach the case where a disabled level-15 source still broadcasts, and the case where masked sources still show in the routed word.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int NSRC = 32;
  localparam int DW   = 32;
  localparam int NLVL = 15;

  localparam logic [DW-1:0] WR_MASK  = 32'hF05DFF80;
  localparam logic [DW-1:0] MASK_RST = 32'h0FA2007F;
  localparam int            MDIS_BIT = 31;

  localparam logic [2:0] OFF_PEND = 3'd0;
  localparam logic [2:0] OFF_MASK = 3'd1;
  localparam logic [2:0] OFF_EN   = 3'd2;
  localparam logic [2:0] OFF_DIS  = 3'd3;
  localparam logic [2:0] OFF_TGT  = 3'd4;

  function automatic logic [3:0] src_level(input logic [4:0] b);
    case (b)
      5'd0, 5'd7:                   return 4'd2;
      5'd1, 5'd8:                   return 4'd3;
      5'd2, 5'd9:                   return 4'd5;
      5'd3, 5'd10:                  return 4'd7;
      5'd4, 5'd11, 5'd21:           return 4'd9;
      5'd5, 5'd12, 5'd22:           return 4'd11;
      5'd6, 5'd13, 5'd17:           return 4'd13;
      5'd14, 5'd15:                 return 4'd12;
      5'd16:                        return 4'd6;
      5'd18:                        return 4'd4;
      5'd19:                        return 4'd10;
      5'd20:                        return 4'd8;
      5'd27, 5'd28, 5'd29, 5'd30:   return 4'd15;
      default:                      return 4'd0;
    endcase
  endfunction

  function automatic logic [DW-1:0] valid_sources();
    logic [DW-1:0] v;
    for (int j = 0; j < NSRC; j++) v[j] = (src_level(5'(j)) != 4'd0);
    return v;
  endfunction

  function automatic logic [DW-1:0] top_level_sources();
    logic [DW-1:0] v;
    for (int j = 0; j < NSRC; j++) v[j] = (src_level(5'(j)) == 4'd15);
    return v;
  endfunction

  function automatic logic [NLVL-1:0] fold_levels(input logic [DW-1:0] p);
    logic [NLVL-1:0] o;
    logic [3:0]      lv;
    o = '0;
    for (int j = 0; j < NSRC; j++) begin
      lv = src_level(5'(j));
      if (p[j] && lv != 4'd0) o[lv - 4'd1] = 1'b1;
    end
    return o;
  endfunction
endpackage

// File: rtl/irq_reg_file.sv
module irq_reg_file
  import irq_router_pkg::*;
#(
  parameter int TGT_W  = 4,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DW-1:0]     src_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  output logic [DW-1:0]     pend_o,
  output logic [DW-1:0]     mask_o,
  output logic [TGT_W-1:0]  tgt_o
);
  localparam logic [DW-1:0] SRC_VALID = valid_sources();
  localparam int            WORD_W    = ADDR_W - 2;

  logic [DW-1:0]    pend_q, pend_d, mask_q, mask_d;
  logic [TGT_W-1:0] tgt_q, tgt_d;
  logic             mask_ce, tgt_ce;
  logic [WORD_W-1:0] word;

  assign word = addr_i[ADDR_W-1:2];

  always_comb begin
    pend_d  = src_i & SRC_VALID;
    mask_d  = mask_q;
    mask_ce = 1'b0;
    tgt_d   = tgt_q;
    tgt_ce  = 1'b0;
    if (wr_i) begin
      if (word == WORD_W'(OFF_EN)) begin
        mask_d  = mask_q & ~(wdata_i & WR_MASK);
        mask_ce = 1'b1;
      end
      if (word == WORD_W'(OFF_DIS)) begin
        mask_d  = mask_q | (wdata_i & WR_MASK);
        mask_ce = 1'b1;
      end
      if (word == WORD_W'(OFF_TGT)) begin
        tgt_d  = wdata_i[TGT_W-1:0];
        tgt_ce = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      mask_q <= MASK_RST;
      tgt_q  <= '0;
    end else begin
      pend_q <= pend_d;
      if (mask_ce) mask_q <= mask_d;
      if (tgt_ce)  tgt_q  <= tgt_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (word == WORD_W'(OFF_PEND))      rdata_o = pend_q & ~(DW'(1) << MDIS_BIT);
    else if (word == WORD_W'(OFF_MASK)) rdata_o = mask_q & WR_MASK;
    else if (word == WORD_W'(OFF_TGT))  rdata_o = DW'(tgt_q);
  end

  assign pend_o = pend_q;
  assign mask_o = mask_q;
  assign tgt_o  = tgt_q;

  AST_MASK_FIXED_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(mask_q & ~WR_MASK)); // R4
  AST_TGT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && word == WORD_W'(OFF_TGT)) |=> (tgt_q == $past(wdata_i[TGT_W-1:0]))); // R6
  AST_OTHER_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && word != WORD_W'(OFF_EN) && word != WORD_W'(OFF_DIS) && word != WORD_W'(OFF_TGT))
    |=> ($stable(mask_q) && $stable(tgt_q))); // R10
endmodule

// File: rtl/irq_level_map.sv
module irq_level_map
  import irq_router_pkg::*;
(
  input  logic [DW-1:0]   pend_i,
  input  logic [DW-1:0]   mask_i,
  output logic [NLVL-1:0] dev_lvl_o,
  output logic [NLVL-1:0] raw_lvl_o,
  output logic            bcast_o,
  output logic            mdis_o
);
  localparam logic [DW-1:0] TOP_SRC = top_level_sources();

  logic [DW-1:0] live;

  always_comb begin
    live      = pend_i & ~mask_i;
    mdis_o    = mask_i[MDIS_BIT];
    dev_lvl_o = fold_levels(live);
    raw_lvl_o = fold_levels(pend_i);
    bcast_o   = |(pend_i & TOP_SRC);
  end
endmodule

// File: rtl/irq_cpu_port.sv
module irq_cpu_port
  import irq_router_pkg::*;
#(
  parameter int IDX   = 0,
  parameter int TGT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TGT_W-1:0] tgt_i,
  input  logic [NLVL-1:0]  dev_lvl_i,
  input  logic [NLVL-1:0]  raw_lvl_i,
  input  logic             bcast_i,
  input  logic             mdis_i,
  output logic [NLVL-1:0]  lvl_o,
  output logic [NLVL-1:0]  routed_o
);
  localparam logic [TGT_W-1:0] MY_ID   = TGT_W'(IDX);
  localparam logic [NLVL-1:0]  TOP_BIT = NLVL'(1) << (NLVL - 1);

  logic [NLVL-1:0] lvl_q, lvl_d, routed_q, routed_d;
  logic            is_tgt;

  always_comb begin
    is_tgt   = (tgt_i == MY_ID);
    lvl_d    = '0;
    routed_d = is_tgt ? raw_lvl_i : '0;
    if (bcast_i) routed_d = routed_d | TOP_BIT;
    if (!mdis_i) begin
      if (is_tgt)  lvl_d = dev_lvl_i;
      if (bcast_i) lvl_d = lvl_d | TOP_BIT;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q    <= '0;
      routed_q <= '0;
    end else begin
      lvl_q    <= lvl_d;
      routed_q <= routed_d;
    end
  end

  assign lvl_o    = lvl_q;
  assign routed_o = routed_q;

  AST_MDIS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    mdis_i |=> (lvl_q == '0)); // R5
  AST_NONTGT_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_i != MY_ID) |=> ((routed_q & ~TOP_BIT) == '0)); // R9
  AST_BCAST_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (bcast_i && !mdis_i) |=> lvl_q[NLVL-1]); // R8
endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
#(
  parameter int NCPU   = 4,
  parameter int TGT_W  = 4,
  parameter int ADDR_W = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [31:0]          src_lvl,
  input  logic                 bus_wr,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  output logic [NCPU*15-1:0]   lvl_out,
  output logic [NCPU*15-1:0]   routed_out
);
  logic [1:0]       rst_sync;
  logic             rst_core_n;
  logic [DW-1:0]    pend, mask;
  logic [TGT_W-1:0] tgt;
  logic [NLVL-1:0]  dev_lvl, raw_lvl;
  logic             bcast, mdis;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_core_n = rst_sync[1];

  irq_reg_file #(.TGT_W(TGT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_core_n), .src_i(src_lvl), .wr_i(bus_wr),
    .addr_i(bus_addr), .wdata_i(bus_wdata), .rdata_o(bus_rdata),
    .pend_o(pend), .mask_o(mask), .tgt_o(tgt)
  );

  irq_level_map u_map (
    .pend_i(pend), .mask_i(mask), .dev_lvl_o(dev_lvl),
    .raw_lvl_o(raw_lvl), .bcast_o(bcast), .mdis_o(mdis)
  );

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    irq_cpu_port #(.IDX(c), .TGT_W(TGT_W)) u_port (
      .clk(clk), .rst_n(rst_core_n), .tgt_i(tgt), .dev_lvl_i(dev_lvl),
      .raw_lvl_i(raw_lvl), .bcast_i(bcast), .mdis_i(mdis),
      .lvl_o(lvl_out[c*NLVL +: NLVL]), .routed_o(routed_out[c*NLVL +: NLVL])
    );
  end
endmodule

// File: tb/tb_irq_router.sv
module tb_irq_router;
  localparam int NCPU = 4;
  localparam int PERIOD = 10;

  typedef struct packed {
    logic [31:0] src;
    logic [3:0]  tgt;
    logic [14:0] lvl;
    logic [14:0] rt;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{32'h0000_0080, 4'd0, 15'h0002, 15'h0002},
    '{32'h0000_0001, 4'd0, 15'h0000, 15'h0002},
    '{32'h0000_C000, 4'd1, 15'h0800, 15'h0800},
    '{32'h0040_0800, 4'd2, 15'h0500, 15'h0500},
    '{32'h1000_0000, 4'd3, 15'h4000, 15'h4000},
    '{32'h0800_0000, 4'd0, 15'h4000, 15'h4000},
    '{32'h0080_0000, 4'd0, 15'h0000, 15'h0000},
    '{32'h8000_0000, 4'd1, 15'h0000, 15'h0000},
    '{32'h0012_0000, 4'd1, 15'h0080, 15'h1080},
    '{32'h0001_0200, 4'd5, 15'h0000, 15'h0000}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] src_lvl = '0;
  logic bus_wr = 1'b0;
  logic [4:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NCPU*15-1:0] lvl_out, routed_out;

  int checks = 0;
  int errors = 0;

  always #(PERIOD/2) clk = ~clk;

  irq_router #(.NCPU(NCPU)) dut (
    .clk(clk), .rst_n(rst_n), .src_lvl(src_lvl), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .lvl_out(lvl_out), .routed_out(routed_out)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  function automatic logic [14:0] lv(input int c);
    return lvl_out[c*15 +: 15];
  endfunction

  function automatic logic [14:0] rt(input int c);
    return routed_out[c*15 +: 15];
  endfunction

  initial begin
    #(PERIOD*100000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    bus_read(5'h00, rd); check("R1 pending", rd, 0);
    bus_read(5'h04, rd); check("R1 mask read", rd, 0);
    bus_read(5'h10, rd); check("R1 target", rd, 0);
    check("R1 levels", 32'(lvl_out), 0);
    check("R1 routed", 32'(routed_out), 0);

    // R11 timing and R1 reset mask: bit 7 enabled, level 2 on cpu 0
    @(negedge clk); src_lvl = 32'h0000_0080;
    @(negedge clk); check("R11 one edge", 32'(lv(0)), 0);
    @(negedge clk); check("R11 two edges", 32'(lv(0)), 32'h0002);
    src_lvl = 32'h0000_0001;
    repeat (2) @(negedge clk);
    check("R1 bit0 disabled lvl", 32'(lv(0)), 0);
    check("R1 bit0 routed", 32'(rt(0)), 32'h0002);

    // R4 open every writable mask bit
    bus_write(5'h08, 32'hFFFF_FFFF);
    bus_read(5'h04, rd); check("R4 all cleared", rd, 0);

    // table: R2 R3 R7 R8 R9 R6
    for (int i = 0; i < NV; i++) begin
      src_lvl = VEC[i].src;
      bus_write(5'h10, 32'(VEC[i].tgt));
      @(negedge clk);
      bus_read(5'h00, rd);
      check("R2 pending read", rd, VEC[i].src & 32'h787F_FFFF);
      for (int c = 0; c < NCPU; c++) begin
        if (c == int'(VEC[i].tgt)) begin
          check("R3 R7 target lvl", 32'(lv(c)), 32'(VEC[i].lvl));
          check("R9 target routed", 32'(rt(c)), 32'(VEC[i].rt));
        end else begin
          check("R8 R7 other lvl", 32'(lv(c)), 32'(VEC[i].lvl & 15'h4000));
          check("R9 other routed", 32'(rt(c)), 32'(VEC[i].rt & 15'h4000));
        end
      end
    end

    // R6 target keeps low four bits
    bus_write(5'h10, 32'h0000_0017);
    bus_read(5'h10, rd); check("R6 target low bits", rd, 32'h7);
    bus_write(5'h10, 32'h0);

    // R5 master disable blocks level outputs, routed stays raw
    bus_write(5'h0C, 32'h8000_0000);
    bus_read(5'h04, rd); check("R5 R4 mdis read", rd, 32'h8000_0000);
    src_lvl = 32'h1000_0080;
    repeat (2) @(negedge clk);
    for (int c = 0; c < NCPU; c++) check("R5 quiet", 32'(lv(c)), 0);
    check("R9 routed under mdis", 32'(rt(0)), 32'h4002);
    bus_write(5'h08, 32'h8000_0000);
    @(negedge clk);
    check("R5 released", 32'(lv(0)), 32'h4002);

    // R4 R7 per-source disable
    bus_write(5'h0C, 32'h0000_FF80);
    bus_read(5'h04, rd); check("R4 set mask", rd, 32'h0000_FF80);
    src_lvl = 32'h0000_0080;
    repeat (2) @(negedge clk);
    check("R7 masked lvl", 32'(lv(0)), 0);
    check("R9 masked routed", 32'(rt(0)), 32'h0002);
    bus_write(5'h08, 32'h0000_FF80);

    // R10 unused offsets
    bus_write(5'h14, 32'hFFFF_FFFF);
    bus_write(5'h00, 32'hFFFF_FFFF);
    bus_read(5'h14, rd); check("R10 read 0x14", rd, 0);
    bus_read(5'h08, rd); check("R10 read 0x08", rd, 0);
    bus_read(5'h04, rd); check("R10 mask kept", rd, 0);
    bus_read(5'h10, rd); check("R10 target kept", rd, 0);
    src_lvl = 32'h0;
    repeat (2) @(negedge clk);
    bus_read(5'h00, rd); check("R10 pending not written", rd, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule